// File: doc/BRIEF.md
# Annealing Sigmoid Lookup Unit

This block converts a stream of signed inner-product sums into neuron activations while it walks through an annealing schedule. Each accepted sum is scaled by the reciprocal of the present temperature and saturated to a signed 6-bit table index. A host-loaded 64-entry table then maps that index to a 5-bit activation. The activation leaves on an output stream together with the neuron index it belongs to, in the order the sums arrived.

The schedule is held in a 16-entry memory. Each entry has a reciprocal value and a sweep count. One sweep is `NEURONS` accepted sums. After the current entry has run for its number of sweeps, the unit moves to the next entry. The anneal ends after the last sum of the last sweep of the final usable entry. The final usable entry is the one before an entry with a zero sweep count, or entry 15. A `start` pulse always rewinds the schedule to entry 0, so the same unit can run a teacher phase and then a student phase. Neurons marked as clamped still produce an output beat, but that beat carries a cleared write enable so that the stored activation is kept.

Both data interfaces are valid/ready. A sum is taken only in a cycle where `sum_valid` and `sum_ready` are both high. `sum_ready` is high only while the unit is busy and its single output register is empty or being drained in that cycle. An output beat stays on the port unchanged until `act_ready` accepts it.

Top module: `asig_anneal_unit`

## Requirements
- R1: After reset, `act_valid`, `sum_ready`, `busy` and `done` are 0 and `temp_step` is 0.
- R2: An accepted sum s, taken while the current schedule entry holds reciprocal r, yields p = floor(s*r/16). The value p is clamped to the range -32..31, and the table address is p+32 (0..63).
- R3: `act_data` equals the table entry at that address as it stood before the clock edge that accepted the sum. A table write on that same edge affects only later sums.
- R4: Each accepted sum produces exactly one output beat, which is valid on the cycle after acceptance. Beats appear in acceptance order, and `act_idx` counts 0..NEURONS-1 within a sweep and then wraps to 0.
- R5: `act_we` is 0 for a beat whose sum arrived with `sum_clamp`=1, and 1 otherwise.
- R6: `sum_ready` = `busy` && (!`act_valid` || `act_ready`). While `act_valid` is high and `act_ready` is low, the beat's data, index and write enable stay unchanged.
- R7: `temp_step` shows the current schedule entry. It advances by one when the last sum of the entry's final sweep is accepted.
- R8: The anneal ends when the final sweep of an entry completes and either that entry is 15 or the next entry's sweep count is 0. At that point `busy` falls and `done` rises in the same cycle, and `done` holds until the next `start`.
- R9: `start` at any time resets the entry, sweep and neuron counters to 0 and clears `done`. If entry 0 has a sweep count of 0, the unit goes straight to `done`=1 with `busy`=0.
- R10: While `busy` is 0, `sum_valid` has no effect: no beat is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lut_wr_en | input | 1 | Table write strobe |
| lut_wr_addr | input | 6 | Table write address |
| lut_wr_data | input | 5 | Table write value |
| sch_wr_en | input | 1 | Schedule write strobe |
| sch_wr_addr | input | 4 | Schedule entry to write |
| sch_wr_recip | input | 8 | Reciprocal temperature, 4 fractional bits |
| sch_wr_sweeps | input | 8 | Sweeps at this entry, 0 ends the schedule |
| start | input | 1 | Rewind the schedule and begin an anneal |
| sum_valid | input | 1 | Sum stream valid |
| sum_ready | output | 1 | Sum stream ready |
| sum_data | input | SUM_W | Signed inner-product sum |
| sum_clamp | input | 1 | Neuron is clamped; keep its stored value |
| act_valid | output | 1 | Activation stream valid |
| act_ready | input | 1 | Activation stream ready |
| act_data | output | 5 | Activation value |
| act_idx | output | log2(NEURONS) | Neuron index within the sweep |
| act_we | output | 1 | Store write enable (0 for clamped neurons) |
| busy | output | 1 | Anneal in progress |
| done | output | 1 | Anneal finished |
| temp_step | output | 4 | Current schedule entry |

## Verification
A neuron counter that is off by one shows up right away in `act_idx` on the next beat. It also moves `temp_step` and `done` by one or more sums relative to the sum count expected from the loaded schedule. A wrong schedule entry or a wrong reciprocal changes `act_data` on the first beat after the step boundary. This is visible only for sums whose scaled value lands in a different table cell, so the bench varies sums and reciprocals widely. Output-register faults under back-pressure show up within one cycle as a changed or dropped beat while `act_ready` is low. Because the bench compares against its reference model on every clock, each of these faults is reported in the cycle where it first reaches a port.

// File: rtl/asig_pkg.sv
package asig_pkg;
  localparam int IDX_W = 6;
  localparam int ACT_W = 5;
  localparam int RCP_W = 8;
  localparam int CNT_W = 8;
  localparam int FRAC  = 4;

  typedef struct packed {
    logic [RCP_W-1:0] recip;
    logic [CNT_W-1:0] sweeps;
  } sched_entry_t;
endpackage

// File: rtl/asig_scale.sv
module asig_scale #(
  parameter int SUM_W = 12,
  parameter int RCP_W = 8,
  parameter int FRAC  = 4,
  parameter int IDX_W = 6
) (
  input  logic signed [SUM_W-1:0] sum_i,
  input  logic        [RCP_W-1:0] recip_i,
  output logic        [IDX_W-1:0] idx_o
);
  localparam int PW = SUM_W + RCP_W + 1;
  localparam logic signed [PW-1:0] HI = PW'((2 ** (IDX_W - 1)) - 1);
  localparam logic signed [PW-1:0] LO = -HI - PW'(1);

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic signed [PW-1:0] sat;

  assign prod   = PW'(sum_i) * PW'($signed({1'b0, recip_i}));
  assign scaled = prod >>> FRAC;

  always_comb begin
    if (scaled > HI)      sat = HI;
    else if (scaled < LO) sat = LO;
    else                  sat = scaled;
  end

  // offset binary: flip the sign bit of the clamped two's-complement value
  assign idx_o = sat[IDX_W-1:0] ^ {1'b1, {(IDX_W-1){1'b0}}};
endmodule

// File: rtl/asig_lut.sv
module asig_lut #(
  parameter int IDX_W = 6,
  parameter int ACT_W = 5
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [ACT_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [ACT_W-1:0] rd_data
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [ACT_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/asig_sched.sv
module asig_sched
  import asig_pkg::*;
#(
  parameter int NEURONS = 128,
  parameter int STEPS   = 16,
  localparam int NW     = $clog2(NEURONS),
  localparam int SW     = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_addr,
  input  sched_entry_t     wr_entry,
  input  logic             start,
  input  logic             adv,
  output logic [RCP_W-1:0] recip,
  output logic [NW-1:0]    nidx,
  output logic [SW-1:0]    step,
  output logic             busy,
  output logic             done
);
  sched_entry_t         table_q [STEPS];
  logic [CNT_W-1:0]     sweep;
  logic [SW-1:0]        step_nx;
  logic                 last_n, last_sw, final_step;

  always_ff @(posedge clk) begin
    if (wr_en) table_q[wr_addr] <= wr_entry;
  end

  assign recip      = table_q[step].recip;
  assign step_nx    = step + 1'b1;
  assign last_n     = (nidx == NW'(NEURONS - 1));
  assign last_sw    = ((sweep + 1'b1) == table_q[step].sweeps);
  assign final_step = (step == SW'(STEPS - 1)) || (table_q[step_nx].sweeps == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      step  <= '0;
      sweep <= '0;
      nidx  <= '0;
    end else if (start) begin
      step  <= '0;
      sweep <= '0;
      nidx  <= '0;
      if (table_q[0].sweeps == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        busy <= 1'b1;
        done <= 1'b0;
      end
    end else if (adv) begin
      if (last_n) begin
        nidx <= '0;
        if (last_sw) begin
          sweep <= '0;
          if (final_step) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            step <= step_nx;
          end
        end else begin
          sweep <= sweep + 1'b1;
        end
      end else begin
        nidx <= nidx + 1'b1;
      end
    end
  end

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step != $past(step)) && !$past(start) |-> $past(adv) && $past(last_n));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (step == '0) && (nidx == '0) && (sweep == '0));
endmodule

// File: rtl/asig_anneal_unit.sv
module asig_anneal_unit
  import asig_pkg::*;
#(
  parameter int SUM_W   = 12,
  parameter int NEURONS = 128,
  parameter int STEPS   = 16,
  localparam int NW     = $clog2(NEURONS),
  localparam int SW     = $clog2(STEPS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lut_wr_en,
  input  logic [IDX_W-1:0]        lut_wr_addr,
  input  logic [ACT_W-1:0]        lut_wr_data,
  input  logic                    sch_wr_en,
  input  logic [SW-1:0]           sch_wr_addr,
  input  logic [RCP_W-1:0]        sch_wr_recip,
  input  logic [CNT_W-1:0]        sch_wr_sweeps,
  input  logic                    start,
  input  logic                    sum_valid,
  output logic                    sum_ready,
  input  logic signed [SUM_W-1:0] sum_data,
  input  logic                    sum_clamp,
  output logic                    act_valid,
  input  logic                    act_ready,
  output logic [ACT_W-1:0]        act_data,
  output logic [NW-1:0]           act_idx,
  output logic                    act_we,
  output logic                    busy,
  output logic                    done,
  output logic [SW-1:0]           temp_step
);
  logic [RCP_W-1:0] recip;
  logic [NW-1:0]    nidx;
  logic [IDX_W-1:0] idx;
  logic [ACT_W-1:0] lut_out;
  logic             accept;
  sched_entry_t     wr_entry;

  assign wr_entry  = '{recip: sch_wr_recip, sweeps: sch_wr_sweeps};
  assign sum_ready = busy && (!act_valid || act_ready);
  assign accept    = sum_valid && sum_ready;

  asig_sched #(.NEURONS(NEURONS), .STEPS(STEPS)) u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (sch_wr_en),
    .wr_addr  (sch_wr_addr),
    .wr_entry (wr_entry),
    .start    (start),
    .adv      (accept),
    .recip    (recip),
    .nidx     (nidx),
    .step     (temp_step),
    .busy     (busy),
    .done     (done)
  );

  asig_scale #(.SUM_W(SUM_W), .RCP_W(RCP_W), .FRAC(FRAC), .IDX_W(IDX_W)) u_scale (
    .sum_i   (sum_data),
    .recip_i (recip),
    .idx_o   (idx)
  );

  asig_lut #(.IDX_W(IDX_W), .ACT_W(ACT_W)) u_lut (
    .clk     (clk),
    .wr_en   (lut_wr_en),
    .wr_addr (lut_wr_addr),
    .wr_data (lut_wr_data),
    .rd_addr (idx),
    .rd_data (lut_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_valid <= 1'b0;
    end else if (accept) begin
      act_valid <= 1'b1;
    end else if (act_ready) begin
      act_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      act_data <= lut_out;
      act_idx  <= nidx;
      act_we   <= !sum_clamp;
    end
  end

  // R6
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && !act_ready |=> act_valid && $stable(act_data) && $stable(act_idx) && $stable(act_we));

  // R4
  beat_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid && sum_ready |=> act_valid);
endmodule

// File: tb/test_asig_anneal_unit.sv
module test_asig_anneal_unit;
  localparam int N  = 8;
  localparam int SW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lut_wr_en = 1'b0;
  logic [5:0] lut_wr_addr = '0;
  logic [4:0] lut_wr_data = '0;
  logic sch_wr_en = 1'b0;
  logic [3:0] sch_wr_addr = '0;
  logic [7:0] sch_wr_recip = '0;
  logic [7:0] sch_wr_sweeps = '0;
  logic start = 1'b0;
  logic sum_valid = 1'b0;
  logic signed [SW-1:0] sum_data = '0;
  logic sum_clamp = 1'b0;
  logic act_ready = 1'b0;
  logic sum_ready, act_valid, act_we, busy, done;
  logic [4:0] act_data;
  logic [2:0] act_idx;
  logic [3:0] temp_step;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  asig_anneal_unit #(.SUM_W(SW), .NEURONS(N)) i_asig_anneal_unit (
    .clk(clk), .rst_n(rst_n),
    .lut_wr_en(lut_wr_en), .lut_wr_addr(lut_wr_addr), .lut_wr_data(lut_wr_data),
    .sch_wr_en(sch_wr_en), .sch_wr_addr(sch_wr_addr), .sch_wr_recip(sch_wr_recip),
    .sch_wr_sweeps(sch_wr_sweeps), .start(start),
    .sum_valid(sum_valid), .sum_ready(sum_ready), .sum_data(sum_data), .sum_clamp(sum_clamp),
    .act_valid(act_valid), .act_ready(act_ready), .act_data(act_data), .act_idx(act_idx),
    .act_we(act_we), .busy(busy), .done(done), .temp_step(temp_step)
  );

  // behavioural reference model
  int lut [64];
  int srec [16];
  int scnt [16];
  bit m_run, m_done, m_ov, m_owe;
  int m_step, m_sw, m_n, m_od, m_oi;

  always @(posedge clk) begin
    bit acc;
    int p;
    if (!rst_n) begin
      m_run = 0; m_done = 0; m_ov = 0; m_step = 0; m_sw = 0; m_n = 0;
    end else begin
      acc = m_run && (!m_ov || act_ready) && sum_valid;
      if (acc) begin
        p = int'(sum_data) * srec[m_step];
        p = p >>> 4;
        if (p > 31) p = 31;
        if (p < -32) p = -32;
        m_od = lut[p + 32]; m_oi = m_n; m_owe = !sum_clamp; m_ov = 1;
      end else if (act_ready) begin
        m_ov = 0;
      end
      if (start) begin
        m_step = 0; m_sw = 0; m_n = 0;
        if (scnt[0] == 0) begin m_run = 0; m_done = 1; end
        else begin m_run = 1; m_done = 0; end
      end else if (acc) begin
        if (m_n == N - 1) begin
          m_n = 0;
          if (m_sw + 1 == scnt[m_step]) begin
            m_sw = 0;
            if (m_step == 15 || scnt[m_step + 1] == 0) begin m_run = 0; m_done = 1; end
            else m_step = m_step + 1;
          end else m_sw = m_sw + 1;
        end else m_n = m_n + 1;
      end
      if (lut_wr_en) lut[lut_wr_addr] = lut_wr_data;
      if (sch_wr_en) begin srec[sch_wr_addr] = sch_wr_recip; scnt[sch_wr_addr] = sch_wr_sweeps; end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R6 sum_ready", sum_ready, m_run && (!m_ov || act_ready));
      chk("R4 R10 act_valid", act_valid, m_ov);
      chk("R8 busy", busy, m_run);
      chk("R8 R9 done", done, m_done);
      chk("R7 temp_step", temp_step, m_step);
      if (m_ov) begin
        chk("R2 R3 act_data", act_data, m_od);
        chk("R4 act_idx", act_idx, m_oi);
        chk("R5 act_we", act_we, m_owe);
      end
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load_lut(int kind);
    for (int i = 0; i < 64; i++) begin
      lut_wr_en = 1; lut_wr_addr = 6'(i);
      lut_wr_data = (kind == 0) ? 5'(i >> 1) : 5'((i * 7 + 3) & 31);
      tick();
    end
    lut_wr_en = 0;
  endtask

  task automatic set_entry(int a, int r, int c);
    sch_wr_en = 1; sch_wr_addr = 4'(a); sch_wr_recip = 8'(r); sch_wr_sweeps = 8'(c);
    tick();
    sch_wr_en = 0;
  endtask

  task automatic pulse_start();
    start = 1; tick(); start = 0;
  endtask

  task automatic send(int s, bit cl);
    sum_valid = 1; sum_data = SW'(s); sum_clamp = cl; act_ready = 1;
    tick();
    sum_valid = 0;
  endtask

  task automatic run_random(int n, int vp, int rp, bit lut_noise);
    for (int i = 0; i < n; i++) begin
      sum_valid = ($urandom_range(0, 99) < vp);
      sum_data  = SW'($urandom_range(0, 4095));
      sum_clamp = ($urandom_range(0, 3) == 0);
      act_ready = ($urandom_range(0, 99) < rp);
      lut_wr_en = lut_noise && ($urandom_range(0, 7) == 0);
      lut_wr_addr = 6'($urandom_range(0, 63));
      lut_wr_data = 5'($urandom_range(0, 31));
      tick();
    end
    sum_valid = 0; lut_wr_en = 0; act_ready = 1;
    tick(); tick();
  endtask

  initial begin
    tick(); tick(); tick();
    // R1: reset state
    @(negedge clk);
    chk("R1 act_valid", act_valid, 0);
    chk("R1 sum_ready", sum_ready, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 temp_step", temp_step, 0);
    @(posedge clk); #1;
    rst_n = 1;
    tick();

    // directed saturation corners with a monotone table (R2)
    load_lut(0);
    set_entry(0, 64, 1);
    for (int a = 1; a < 16; a++) set_entry(a, 16, 0);
    pulse_start();
    send(2047, 0);
    send(-2048, 0);
    send(5, 1);
    send(-1, 0);
    send(0, 0);
    send(7, 0);
    send(-9, 1);
    send(100, 0);
    tick();
    @(negedge clk);
    chk("R8 done after one sweep", done, 1);
    chk("R8 busy after one sweep", busy, 0);
    @(posedge clk); #1;
    // R10: sums offered while idle must not produce beats
    sum_valid = 1; sum_data = 12'sd300; act_ready = 1;
    tick(); tick(); tick();
    sum_valid = 0;
    @(negedge clk);
    chk("R10 no beat while idle", act_valid, 0);
    @(posedge clk); #1;

    // multi-step schedule with back-pressure (R6 R7)
    load_lut(1);
    set_entry(0, 16, 2);
    set_entry(1, 64, 1);
    set_entry(2, 4, 1);
    set_entry(3, 200, 0);
    pulse_start();
    run_random(400, 70, 50, 0);
    // second phase: restart from entry 0 (R9)
    pulse_start();
    run_random(300, 90, 80, 1);

    // full 16-entry schedule ends after entry 15 (R8)
    for (int a = 0; a < 16; a++) set_entry(a, 3 + a * 13, 1);
    pulse_start();
    run_random(700, 80, 70, 1);
    @(negedge clk);
    chk("R8 done after entry 15", done, 1);
    @(posedge clk); #1;

    // restart in the middle of an anneal (R9)
    pulse_start();
    run_random(25, 80, 80, 0);
    pulse_start();
    run_random(700, 60, 60, 0);

    // zero sweeps at entry 0 finishes at once (R9)
    set_entry(0, 10, 0);
    pulse_start();
    @(negedge clk);
    chk("R9 immediate done", done, 1);
    chk("R9 immediate busy", busy, 0);
    @(posedge clk); #1;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule